// File: doc/BRIEF.md
# Clock Stop and Power-Down Gate

This block sits between a bank of free-running clock sources and the pins of a clock generator. It gates a set of single-ended clock outputs and a set of differential clock outputs. Three things can silence an output: its enable bit, a software stop request that applies only to outputs marked as stoppable, and a power-down request. Every stop and every restart happens on a safe edge of the output's own clock, so no output ever shows a pulse shorter than half a period of its source.

The power-down request is asynchronous. It is accepted only after it has been seen high on two consecutive rising edges of a qualifying clock. In a real generator this is the CPU complement clock. Once it is accepted, single-ended outputs park low on their next falling edge. Differential outputs park with the true leg high, on the next rising edge of the true leg, which is the falling edge of the complement leg. A per-output mode bit chooses the parked drive. In driven mode the true leg is driven high and the complement leg is floated. In float mode both legs are floated. Outputs stopped by software use one shared mode bit in the same way.

On release, floated differential outputs are driven high again as soon as the request drop is seen. Clocks restart only once the lock input is high. The request and the lock input are both sampled on the qualifying clock.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is asserted every single-ended output is low, every differential true leg is 1 with its output enable equal to its enable bit, and every complement enable is 0; after reset is released, with all enables 1 and nothing stopped, every output toggles and every differential output has both leg enables at 1.
- R2: A power-down request that is high on only one rising edge of the qualifying clock is ignored: all outputs keep toggling.
- R3: A power-down request high on two consecutive rising edges of the qualifying clock parks every output within 4 qualifying-clock periods after the second of those edges: single-ended outputs are held at 0 and differential true legs are held at 1.
- R4: While parked by power-down, a differential output whose power-down mode bit is 0 has true-leg enable 1 and complement-leg enable 0; with the bit at 1, both leg enables are 0.
- R5: With the software run bit at 0, every output whose stoppable bit is 1 stops (single-ended at 0, differential true at 1) while outputs with stoppable bit 0 keep toggling; returning the run bit to 1 restarts the stopped outputs.
- R6: A differential output stopped by software has complement enable 0 and true-leg enable equal to the inverse of the shared stop mode bit (0 = driven high, 1 = floated).
- R7: An output whose enable bit is 0 is off whatever the stop and power-down state: single-ended at 0, differential with both leg enables at 0. The differential enables drop at once, without waiting for a clock edge.
- R8: After the power-down request falls, a floated differential output has its true-leg enable back at 1 within 4 qualifying-clock periods. The outputs stay parked while the lock input is 0. The park is left only after two consecutive low samples of the request taken with the lock input at 1, and after that all outputs toggle again.
- R9: No output ever shows a high or low phase shorter than half a period of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| pd_clk | input | 1 | Qualifying clock for the power-down request and the lock input |
| pd_req | input | 1 | Asynchronous power-down request, active high |
| pll_lock | input | 1 | Lock indication; 1 lets parked outputs restart after power-down |
| sw_run | input | 1 | Software run bit; 0 stops all stoppable outputs |
| stop_hiz | input | 1 | Parked drive for differential outputs stopped by software (1 = float) |
| se_clk_in | input | N_SE | Single-ended source clocks |
| se_en | input | N_SE | Single-ended output enables |
| se_stoppable | input | N_SE | Single-ended stoppable mask |
| se_clk_out | output | N_SE | Gated single-ended clocks |
| df_clk_in | input | N_DF | Differential source clocks (true phase) |
| df_en | input | N_DF | Differential output enables |
| df_stoppable | input | N_DF | Differential stoppable mask |
| df_pd_hiz | input | N_DF | Parked drive under power-down, per output (1 = float) |
| df_t_out | output | N_DF | Differential true-leg data |
| df_c_out | output | N_DF | Differential complement-leg data |
| df_t_oe | output | N_DF | True-leg output enable |
| df_c_oe | output | N_DF | Complement-leg output enable |

## Verification
A synchronizer stage or a gate latch holding the wrong value shows up as one of three faults. An output may keep toggling after a stop, sit parked when it should run, or show a clipped phase at the pin. The stop faults appear within a few source cycles of the request. A park that starts from a single-sample request, or that ends before lock is high, is visible on the first edge after the request changes. A wrong parked drive mode is visible on the leg enables as soon as the output has parked. A gate that opens in the wrong clock phase is visible only as a phase width shorter than half a period, so every phase of every output is measured over the whole run.

// File: rtl/clk_stop_gate_pkg.sv
`timescale 1ns/1ps
package clk_stop_gate_pkg;
  // request handed to a differential gate cell, produced in the qualifying domain
  typedef struct packed {
    logic run;   // 1 = output may toggle
    logic hiz;   // 1 = float both legs while parked
  } gate_req_t;
endpackage

// File: rtl/clk_stop_rst_sync.sv
`timescale 1ns/1ps
module clk_stop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/clk_stop_pd_qual.sv
`timescale 1ns/1ps
module clk_stop_pd_qual (
  input  logic pd_clk,
  input  logic arst_n,
  input  logic pd_req,
  input  logic pll_lock,
  output logic pd_park,
  output logic pd_float
);
  logic rst_l;
  logic smp_q, park_q, float_q;
  logic park_d, float_d;

  clk_stop_rst_sync #(.STAGES(2)) u_rst (
    .clk(pd_clk), .arst_n(arst_n), .rst_n_o(rst_l)
  );

  // park: set on two high samples in a row, cleared on two low samples with lock
  always_comb begin
    if (park_q) park_d = !(!pd_req && !smp_q && pll_lock);
    else        park_d = pd_req && smp_q;
    float_d = park_d && pd_req;
  end

  always_ff @(posedge pd_clk or negedge rst_l) begin
    if (!rst_l) begin
      smp_q   <= 1'b0;
      park_q  <= 1'b0;
      float_q <= 1'b0;
    end else begin
      smp_q   <= pd_req;
      park_q  <= park_d;
      float_q <= float_d;
    end
  end

  assign pd_park  = park_q;
  assign pd_float = float_q;
endmodule

// File: rtl/clk_stop_se_cell.sv
`timescale 1ns/1ps
module clk_stop_se_cell #(
  parameter int STAGES = 2
) (
  input  logic clk_src,
  input  logic arst_n,
  input  logic run_req,
  output logic clk_out
);
  logic rst_l;
  logic [STAGES-1:0] run_q;
  logic [STAGES-1:0] run_d;
  logic run_lat;

  clk_stop_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk_src), .arst_n(arst_n), .rst_n_o(rst_l)
  );

  always_comb run_d = {run_q[STAGES-2:0], run_req};

  always_ff @(posedge clk_src or negedge rst_l) begin
    if (!rst_l) run_q <= '0;
    else        run_q <= run_d;
  end

  // gate opens only while the source is low, so changes land on a falling edge
  always_latch begin
    if (!rst_l)        run_lat = 1'b0;
    else if (!clk_src) run_lat = run_q[STAGES-1];
  end

  assign clk_out = clk_src & run_lat;
endmodule

// File: rtl/clk_stop_df_cell.sv
`timescale 1ns/1ps
module clk_stop_df_cell
  import clk_stop_gate_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk_src,
  input  logic      arst_n,
  input  logic      en,
  input  gate_req_t req,
  output logic      t_out,
  output logic      c_out,
  output logic      t_oe,
  output logic      c_oe
);
  logic clk_n;
  logic rst_l;
  logic [STAGES-1:0] run_q, run_d;
  logic [STAGES-1:0] hiz_q, hiz_d;
  logic run_lat;

  assign clk_n = ~clk_src;

  // this domain runs on the complement rising edge
  clk_stop_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk_n), .arst_n(arst_n), .rst_n_o(rst_l)
  );

  always_comb begin
    run_d = {run_q[STAGES-2:0], req.run};
    hiz_d = {hiz_q[STAGES-2:0], req.hiz};
  end

  always_ff @(posedge clk_n or negedge rst_l) begin
    if (!rst_l) begin
      run_q <= '0;
      hiz_q <= '0;
    end else begin
      run_q <= run_d;
      hiz_q <= hiz_d;
    end
  end

  // gate opens only while the true leg is high: park happens at its rising edge
  always_latch begin
    if (!rst_l)       run_lat = 1'b0;
    else if (clk_src) run_lat = run_q[STAGES-1];
  end

  assign t_out = clk_src | ~run_lat;
  assign c_out = ~t_out;
  assign c_oe  = en & run_lat;
  assign t_oe  = en & (run_lat | ~hiz_q[STAGES-1]);
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
  import clk_stop_gate_pkg::*;
#(
  parameter int N_SE        = 3,
  parameter int N_DF        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            rst_n,
  input  logic            pd_clk,
  input  logic            pd_req,
  input  logic            pll_lock,
  input  logic            sw_run,
  input  logic            stop_hiz,
  input  logic [N_SE-1:0] se_clk_in,
  input  logic [N_SE-1:0] se_en,
  input  logic [N_SE-1:0] se_stoppable,
  output logic [N_SE-1:0] se_clk_out,
  input  logic [N_DF-1:0] df_clk_in,
  input  logic [N_DF-1:0] df_en,
  input  logic [N_DF-1:0] df_stoppable,
  input  logic [N_DF-1:0] df_pd_hiz,
  output logic [N_DF-1:0] df_t_out,
  output logic [N_DF-1:0] df_c_out,
  output logic [N_DF-1:0] df_t_oe,
  output logic [N_DF-1:0] df_c_oe
);
  logic pd_park;
  logic pd_float;

  clk_stop_pd_qual u_pd (
    .pd_clk(pd_clk), .arst_n(rst_n), .pd_req(pd_req), .pll_lock(pll_lock),
    .pd_park(pd_park), .pd_float(pd_float)
  );

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    logic run_req;
    assign run_req = se_en[i] & ~pd_park & (sw_run | ~se_stoppable[i]);
    clk_stop_se_cell #(.STAGES(SYNC_STAGES)) u_cell (
      .clk_src(se_clk_in[i]), .arst_n(rst_n), .run_req(run_req),
      .clk_out(se_clk_out[i])
    );
  end

  for (genvar j = 0; j < N_DF; j++) begin : g_df
    gate_req_t req;
    always_comb begin
      req.run = df_en[j] & ~pd_park & (sw_run | ~df_stoppable[j]);
      // float under power-down per output; once the request drops, drive high
      if (pd_float)     req.hiz = df_pd_hiz[j];
      else if (pd_park) req.hiz = 1'b0;
      else              req.hiz = stop_hiz;
    end
    clk_stop_df_cell #(.STAGES(SYNC_STAGES)) u_cell (
      .clk_src(df_clk_in[j]), .arst_n(rst_n), .en(df_en[j]), .req(req),
      .t_out(df_t_out[j]), .c_out(df_c_out[j]),
      .t_oe(df_t_oe[j]), .c_oe(df_c_oe[j])
    );
  end
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
  parameter int N_SE     = 3,
  parameter int N_DF     = 2,
  parameter int PARK_WIN = 4
) (
  input logic            pd_clk,
  input logic            rst_n,
  input logic            pd_req,
  input logic            pll_lock,
  input logic            pd_park,
  input logic            pd_float,
  input logic [N_SE-1:0] se_clk_out,
  input logic [N_DF-1:0] df_t_out,
  input logic [N_DF-1:0] df_t_oe,
  input logic [N_DF-1:0] df_c_oe,
  input logic [N_DF-1:0] df_en
);
  localparam int CW = $clog2(PARK_WIN + 1);
  logic [CW-1:0] win_cnt, win_cnt_d;

  always_comb begin
    if (!pd_park)                      win_cnt_d = '0;
    else if (win_cnt != CW'(PARK_WIN)) win_cnt_d = win_cnt + 1'b1;
    else                               win_cnt_d = win_cnt;
  end

  always_ff @(posedge pd_clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else        win_cnt <= win_cnt_d;
  end

  // R2
  pd_two_sample_chk: assert property (@(posedge pd_clk) disable iff (!rst_n)
    $rose(pd_park) |-> ($past(pd_req) && $past(pd_req, 2)));

  // R3
  park_window_chk: assert property (@(posedge pd_clk) disable iff (!rst_n)
    (win_cnt == CW'(PARK_WIN)) |-> ((se_clk_out == '0) && (&df_t_out)));

  // R8
  lock_release_chk: assert property (@(posedge pd_clk) disable iff (!rst_n)
    $fell(pd_park) |-> $past(pll_lock));

  // R8
  float_release_chk: assert property (@(posedge pd_clk) disable iff (!rst_n)
    $fell(pd_float) |-> !$past(pd_req));

  // R7
  disable_off_chk: assert property (@(posedge pd_clk) disable iff (!rst_n)
    ((df_t_oe | df_c_oe) & ~df_en) == '0);
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_SE(N_SE), .N_DF(N_DF)) u_chk (
  .pd_clk(pd_clk), .rst_n(rst_n), .pd_req(pd_req), .pll_lock(pll_lock),
  .pd_park(pd_park), .pd_float(pd_float), .se_clk_out(se_clk_out),
  .df_t_out(df_t_out), .df_t_oe(df_t_oe), .df_c_oe(df_c_oe), .df_en(df_en)
);

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;
  localparam int N_SE = 3;
  localparam int N_DF = 2;

  logic clk, clk_b, clk_c;
  logic rst_n, pd_req, pll_lock, sw_run, stop_hiz;
  logic [N_SE-1:0] se_en, se_stoppable, se_clk_out, se_clk_in;
  logic [N_DF-1:0] df_en, df_stoppable, df_pd_hiz, df_clk_in;
  logic [N_DF-1:0] df_t_out, df_c_out, df_t_oe, df_c_oe;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  initial begin clk = 0; forever #10 clk = ~clk; end
  initial begin clk_b = 0; #3; forever #8 clk_b = ~clk_b; end
  initial begin clk_c = 0; #1; forever #7 clk_c = ~clk_c; end

  assign se_clk_in = {clk_b, clk_b, clk};
  assign df_clk_in = {clk, clk_c};

  clk_stop_gate #(.N_SE(N_SE), .N_DF(N_DF)) u_dut (
    .rst_n(rst_n), .pd_clk(clk), .pd_req(pd_req), .pll_lock(pll_lock),
    .sw_run(sw_run), .stop_hiz(stop_hiz),
    .se_clk_in(se_clk_in), .se_en(se_en), .se_stoppable(se_stoppable),
    .se_clk_out(se_clk_out),
    .df_clk_in(df_clk_in), .df_en(df_en), .df_stoppable(df_stoppable),
    .df_pd_hiz(df_pd_hiz), .df_t_out(df_t_out), .df_c_out(df_c_out),
    .df_t_oe(df_t_oe), .df_c_oe(df_c_oe)
  );

  // edge counters and phase-width monitors, one per output
  int unsigned se_rise_w [N_SE];
  int unsigned se_runt_w [N_SE];
  int unsigned df_rise_w [N_DF];
  int unsigned df_runt_w [N_DF];

  for (genvar g = 0; g < N_SE; g++) begin : g_se_mon
    int unsigned rises = 0;
    int unsigned runts = 0;
    realtime last_t = 0;
    real half;
    assign half = (g == 0) ? 10.0 : 8.0;
    always @(se_clk_out[g]) begin
      if (se_clk_out[g] === 1'b1) rises++;
      if (last_t > 0 && ($realtime - last_t) < half - 0.5) runts++;
      last_t = $realtime;
    end
    assign se_rise_w[g] = rises;
    assign se_runt_w[g] = runts;
  end

  for (genvar g = 0; g < N_DF; g++) begin : g_df_mon
    int unsigned rises = 0;
    int unsigned runts = 0;
    realtime last_t = 0;
    real half;
    assign half = (g == 0) ? 7.0 : 10.0;
    always @(df_t_out[g]) begin
      if (df_t_out[g] === 1'b1) rises++;
      if (last_t > 0 && ($realtime - last_t) < half - 0.5) runts++;
      last_t = $realtime;
    end
    assign df_rise_w[g] = rises;
    assign df_runt_w[g] = runts;
  end

  int se_d [N_SE];
  int df_d [N_DF];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // count rising edges of every output over 10 qualifying-clock periods
  task automatic window();
    int unsigned se_b [N_SE];
    int unsigned df_b [N_DF];
    for (int i = 0; i < N_SE; i++) se_b[i] = se_rise_w[i];
    for (int i = 0; i < N_DF; i++) df_b[i] = df_rise_w[i];
    repeat (10) @(posedge clk);
    #3;
    for (int i = 0; i < N_SE; i++) se_d[i] = int'(se_rise_w[i] - se_b[i]);
    for (int i = 0; i < N_DF; i++) df_d[i] = int'(df_rise_w[i] - df_b[i]);
  endtask

  task automatic expect_all_running(input string req);
    window();
    for (int i = 0; i < N_SE; i++) chk(se_d[i] >= 5, req, $sformatf("se%0d edges", i), se_d[i], 5);
    for (int i = 0; i < N_DF; i++) chk(df_d[i] >= 5, req, $sformatf("df%0d edges", i), df_d[i], 5);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #3;
    // R1 reset state
    chk(se_clk_out == 3'b000, "R1", "se during reset", se_clk_out, 0);
    chk(df_t_out == 2'b11, "R1", "df true during reset", df_t_out, 3);
    chk(df_t_oe == 2'b11, "R1", "df true oe during reset", df_t_oe, 3);
    chk(df_c_oe == 2'b00, "R1", "df comp oe during reset", df_c_oe, 0);
    @(negedge clk) rst_n = 1;
    repeat (6) @(posedge clk);
    expect_all_running("R1");
    chk(df_t_oe == 2'b11 && df_c_oe == 2'b11, "R1", "df oe running",
        {df_t_oe, df_c_oe}, 15);
  endtask

  task automatic t_pd_glitch();
    @(negedge clk) pd_req = 1;
    @(negedge clk) pd_req = 0;
    repeat (2) @(posedge clk);
    // R2 single sample ignored
    expect_all_running("R2");
  endtask

  task automatic t_pd_park();
    df_pd_hiz = 2'b10;
    pll_lock = 0;
    @(negedge clk) pd_req = 1;
    repeat (2) @(posedge clk);
    repeat (4) @(posedge clk);
    #3;
    // R3 parked within 4 periods
    chk(se_clk_out == 3'b000, "R3", "se parked low", se_clk_out, 0);
    chk(df_t_out == 2'b11, "R3", "df true parked high", df_t_out, 3);
    // R4 drive modes
    chk(df_t_oe == 2'b01, "R4", "df true oe by pd mode", df_t_oe, 1);
    chk(df_c_oe == 2'b00, "R4", "df comp oe parked", df_c_oe, 0);
    window();
    for (int i = 0; i < N_SE; i++) chk(se_d[i] == 0, "R3", $sformatf("se%0d stays parked", i), se_d[i], 0);
    for (int i = 0; i < N_DF; i++) chk(df_d[i] == 0, "R3", $sformatf("df%0d stays parked", i), df_d[i], 0);
  endtask

  task automatic t_pd_release();
    @(negedge clk) pd_req = 0;
    repeat (4) @(posedge clk);
    #3;
    // R8 floated output driven again, still parked without lock
    chk(df_t_oe == 2'b11, "R8", "df true oe after release", df_t_oe, 3);
    chk(df_c_oe == 2'b00, "R8", "df comp oe without lock", df_c_oe, 0);
    window();
    chk(se_d[0] == 0 && df_d[0] == 0, "R8", "no restart without lock", se_d[0] + df_d[0], 0);
    chk(df_t_out == 2'b11, "R8", "df true held without lock", df_t_out, 3);
    @(negedge clk) pll_lock = 1;
    repeat (6) @(posedge clk);
    expect_all_running("R8");
    df_pd_hiz = 2'b00;
  endtask

  task automatic t_sw_stop();
    se_stoppable = 3'b010;
    df_stoppable = 2'b01;
    stop_hiz = 1;
    @(negedge clk) sw_run = 0;
    repeat (6) @(posedge clk);
    #3;
    // R5 masked outputs stop, R6 float mode
    chk(se_clk_out[1] == 1'b0, "R5", "se1 stopped low", se_clk_out[1], 0);
    chk(df_t_out[0] == 1'b1, "R5", "df0 stopped high", df_t_out[0], 1);
    chk(df_t_oe == 2'b10, "R6", "df true oe float mode", df_t_oe, 2);
    chk(df_c_oe == 2'b10, "R6", "df comp oe stopped", df_c_oe, 2);
    window();
    chk(se_d[1] == 0, "R5", "se1 no edges", se_d[1], 0);
    chk(df_d[0] == 0, "R5", "df0 no edges", df_d[0], 0);
    chk(se_d[0] >= 5 && se_d[2] >= 5, "R5", "unmasked se run", se_d[0] < se_d[2] ? se_d[0] : se_d[2], 5);
    chk(df_d[1] >= 5, "R5", "unmasked df1 runs", df_d[1], 5);
    stop_hiz = 0;
    repeat (6) @(posedge clk);
    #3;
    chk(df_t_oe == 2'b11, "R6", "df true oe driven mode", df_t_oe, 3);
    chk(df_c_oe == 2'b10 && df_t_out[0] == 1'b1, "R6", "df0 driven high, comp off",
        {df_c_oe, df_t_out[0]}, 5);
    @(negedge clk) sw_run = 1;
    repeat (6) @(posedge clk);
    expect_all_running("R5");
    se_stoppable = '0;
    df_stoppable = '0;
  endtask

  task automatic t_disable();
    df_stoppable = 2'b10;
    @(negedge clk) begin
      se_en = 3'b011;
      df_en = 2'b01;
      sw_run = 0;
    end
    #1;
    // R7 immediate float, even with a driven stop mode
    chk(df_t_oe[1] == 1'b0 && df_c_oe[1] == 1'b0, "R7", "df1 legs off at once",
        {df_t_oe[1], df_c_oe[1]}, 0);
    repeat (6) @(posedge clk);
    window();
    chk(se_d[2] == 0 && se_clk_out[2] == 1'b0, "R7", "se2 off", se_d[2], 0);
    chk(df_t_oe[1] == 1'b0 && df_c_oe[1] == 1'b0, "R7", "df1 legs stay off",
        {df_t_oe[1], df_c_oe[1]}, 0);
    chk(se_d[0] >= 5 && df_d[0] >= 5, "R7", "enabled outputs run", se_d[0], 5);
    @(negedge clk) begin
      se_en = '1;
      df_en = '1;
      sw_run = 1;
    end
    df_stoppable = '0;
    repeat (6) @(posedge clk);
    expect_all_running("R7");
  endtask

  task automatic t_runt();
    int total = 0;
    for (int i = 0; i < N_SE; i++) total += int'(se_runt_w[i]);
    for (int i = 0; i < N_DF; i++) total += int'(df_runt_w[i]);
    // R9 no short phase anywhere in the run
    chk(total == 0, "R9", "short phases seen", total, 0);
  endtask

  initial begin
    rst_n = 0; pd_req = 0; pll_lock = 1; sw_run = 1; stop_hiz = 0;
    se_en = '1; se_stoppable = '0;
    df_en = '1; df_stoppable = '0; df_pd_hiz = '0;
    t_reset();
    t_pd_glitch();
    t_pd_park();
    t_pd_release();
    t_sw_stop();
    t_disable();
    t_runt();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule